// File: doc/BRIEF.md
# Sequential single-precision restoring divider

This block divides one IEEE-754 single-precision value by another over a fixed number of clock cycles, using a shift-and-subtract mantissa loop that yields one quotient bit per cycle. Each operand arrives as a pair of 16-bit halves, the dividend on `a_hi`/`a_lo` and the divisor on `b_hi`/`b_lo`. A one-cycle `start` pulse while the block is idle captures both operands and the rounding mode. Exactly 30 cycles later the block raises `done` for one cycle, and the quotient then sits on `q_hi`/`q_lo` until the next result replaces it.

The block computes the sign, the biased exponent, the quotient mantissa, the normalization shift and the rounding. The operands are assumed to be normalized and non-zero, and the result is assumed to lie in the normal range. Zero divisors, special values, subnormals and exception reporting are outside its function.

Top module: `spdiv_seq`

## Requirements
- R1: With `busy` low, a cycle with `start` high captures the dividend `{a_hi,a_lo}`, the divisor `{b_hi,b_lo}` and `rnd_mode`, and `busy` goes high from the next cycle. Each operand uses bit 31 as the sign, bits 30:23 as the biased exponent and bits 22:0 as the fraction with a hidden leading 1.
- R2: `done` is high for exactly one cycle. It rises at the 30th rising edge after the capturing edge. `busy` falls at that same edge.
- R3: Bit 31 of the result is the XOR of the two operand sign bits.
- R4: The result exponent is the dividend exponent minus the divisor exponent plus 127. It is one less when the dividend mantissa is smaller than the divisor mantissa, because the leading quotient bit is then 0 and the quotient is shifted left by one place.
- R5: The quotient mantissa comes from a restoring loop. At each step, when the divisor is at most the partial remainder, the divisor is subtracted and a 1 is shifted into the quotient. Otherwise a 0 is shifted in and nothing is subtracted. The remainder is then doubled. The loop runs long enough to produce 24 mantissa bits plus one round bit, and the sticky bit is set when any later quotient bit or the final remainder is non-zero.
- R6: With `rnd_mode` = 0 (round to nearest, ties to even), the truncated mantissa is incremented when the round bit is 1 and either the sticky bit or the mantissa LSB is 1. A carry out of the mantissa raises the exponent by one.
- R7: With `rnd_mode` = 1 (round toward zero), the result is the truncated mantissa.
- R8: A `start` pulse while `busy` is high is ignored. It produces no extra `done`, and it does not alter the result of the operation in progress.
- R9: After reset `busy`, `done`, `q_hi` and `q_lo` are all 0. The result outputs change only at the edge that raises `done`, and they hold their value until the next such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division when idle |
| rnd_mode | input | 1 | 0 = nearest-even, 1 = toward zero |
| a_hi | input | 16 | Dividend bits 31:16 |
| a_lo | input | 16 | Dividend bits 15:0 |
| b_hi | input | 16 | Divisor bits 31:16 |
| b_lo | input | 16 | Divisor bits 15:0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| q_hi | output | 16 | Quotient bits 31:16 |
| q_lo | output | 16 | Quotient bits 15:0 |

## Verification
The case that is hardest to reach from the ports is a second `start` that lands in the middle of a running operation. Its operands must be discarded, and the running operation must still finish on schedule with the first operands' result. The bench issues a division and, ten cycles into it, pulses `start` again with different operands and the other rounding mode. It then checks that exactly one `done` appears, carrying the first expected quotient, and that no stray `done` follows in the idle cycles afterwards. Divisions whose dividend mantissa is below the divisor mantissa reach the exponent-decrement path. Random operand pairs in both rounding modes exercise the round and sticky logic.

// File: rtl/spdiv_pkg.sv
package spdiv_pkg;

    localparam int unsigned HALF_W = 16;
    localparam int unsigned WORD_W = 2 * HALF_W;
    localparam int unsigned EXP_W  = 8;
    localparam int unsigned FRAC_W = 23;
    localparam int unsigned MANT_W = FRAC_W + 1;
    localparam int unsigned BIAS   = 127;
    // quotient bits: one possible leading zero, 24 mantissa bits, one round bit
    localparam int unsigned QBITS  = MANT_W + 2;
    localparam int unsigned REM_W  = MANT_W + 2;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } sp_word_t;

    typedef enum logic {
        RND_NEAREST_EVEN = 1'b0,
        RND_TOWARD_ZERO  = 1'b1
    } rnd_mode_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
        logic              rnd_bit;
        logic              sticky;
    } norm_t;

    function automatic logic [MANT_W-1:0] with_hidden(input sp_word_t w);
        return {1'b1, w.frac};
    endfunction

endpackage

// File: rtl/spdiv_ctrl.sv
module spdiv_ctrl #(
    parameter int unsigned LATENCY = 30,
    parameter int unsigned STEPS   = 26
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic accept,
    output logic step_en,
    output logic norm_en,
    output logic round_en,
    output logic finish
);
    localparam int unsigned CNT_W = $clog2(LATENCY + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    assign accept   = start & ~busy_q;
    assign busy     = busy_q;
    assign step_en  = busy_q & (cnt_q < CNT_W'(STEPS));
    assign norm_en  = busy_q & (cnt_q == CNT_W'(STEPS));
    assign round_en = busy_q & (cnt_q == CNT_W'(STEPS + 1));
    assign finish   = busy_q & (cnt_q == CNT_W'(LATENCY - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (finish) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spdiv_remstep.sv
module spdiv_remstep #(
    parameter int unsigned REM_W = 26,
    parameter int unsigned DIV_W = 24
) (
    input  logic [REM_W-1:0] rem,
    input  logic [DIV_W-1:0] divisor,
    output logic [REM_W-1:0] rem_next,
    output logic             qbit
);
    logic [REM_W-1:0] div_ext;
    logic [REM_W-1:0] diff;

    assign div_ext  = REM_W'(divisor);
    assign qbit     = (rem >= div_ext);
    assign diff     = qbit ? (rem - div_ext) : rem;
    assign rem_next = diff << 1;

endmodule

// File: rtl/spdiv_round.sv
module spdiv_round
    import spdiv_pkg::*;
(
    input  norm_t     norm,
    input  rnd_mode_e mode,
    output sp_word_t  result
);
    logic            inc;
    logic [MANT_W:0] sum;

    always_comb begin
        inc = (mode == RND_NEAREST_EVEN) & norm.rnd_bit & (norm.sticky | norm.mant[0]);
        sum = {1'b0, norm.mant} + (MANT_W + 1)'(inc);
        result.sign = norm.sign;
        if (sum[MANT_W]) begin
            result.exp  = norm.exp + 1'b1;
            result.frac = sum[FRAC_W:1];
        end else begin
            result.exp  = norm.exp;
            result.frac = sum[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/spdiv_seq.sv
module spdiv_seq
    import spdiv_pkg::*;
#(
    parameter int unsigned LATENCY = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rnd_mode,
    input  logic [HALF_W-1:0] a_hi,
    input  logic [HALF_W-1:0] a_lo,
    input  logic [HALF_W-1:0] b_hi,
    input  logic [HALF_W-1:0] b_lo,
    output logic              busy,
    output logic              done,
    output logic [HALF_W-1:0] q_hi,
    output logic [HALF_W-1:0] q_lo
);
    sp_word_t op_a, op_b;
    assign op_a = sp_word_t'({a_hi, a_lo});
    assign op_b = sp_word_t'({b_hi, b_lo});

    logic accept, step_en, norm_en, round_en, finish;

    spdiv_ctrl #(.LATENCY(LATENCY), .STEPS(QBITS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .busy     (busy),
        .accept   (accept),
        .step_en  (step_en),
        .norm_en  (norm_en),
        .round_en (round_en),
        .finish   (finish)
    );

    // working state
    logic              sign_q;
    logic [EXP_W-1:0]  exp_q;
    logic [MANT_W-1:0] div_q;
    logic [REM_W-1:0]  rem_q;
    logic [QBITS-1:0]  quo_q;
    rnd_mode_e         mode_q;
    norm_t             norm_q;
    sp_word_t          res_q;
    logic [WORD_W-1:0] out_q;
    logic              done_q;

    logic [REM_W-1:0]  rem_nx;
    logic              qbit;

    spdiv_remstep #(.REM_W(REM_W), .DIV_W(MANT_W)) u_step (
        .rem      (rem_q),
        .divisor  (div_q),
        .rem_next (rem_nx),
        .qbit     (qbit)
    );

    // normalization: leading quotient bit decides the window and exponent
    norm_t norm_d;
    always_comb begin
        norm_d.sign = sign_q;
        if (quo_q[QBITS-1]) begin
            norm_d.exp     = exp_q;
            norm_d.mant    = quo_q[QBITS-1:2];
            norm_d.rnd_bit = quo_q[1];
            norm_d.sticky  = quo_q[0] | (|rem_q);
        end else begin
            norm_d.exp     = exp_q - 1'b1;
            norm_d.mant    = quo_q[QBITS-2:1];
            norm_d.rnd_bit = quo_q[0];
            norm_d.sticky  = |rem_q;
        end
    end

    sp_word_t rounded;
    spdiv_round u_round (
        .norm   (norm_q),
        .mode   (mode_q),
        .result (rounded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sign_q <= 1'b0;
            exp_q  <= '0;
            div_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            mode_q <= RND_NEAREST_EVEN;
            norm_q <= '0;
            res_q  <= '0;
            out_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                sign_q <= op_a.sign ^ op_b.sign;
                exp_q  <= op_a.exp - op_b.exp + EXP_W'(BIAS);
                div_q  <= with_hidden(op_b);
                rem_q  <= REM_W'(with_hidden(op_a));
                quo_q  <= '0;
                mode_q <= rnd_mode_e'(rnd_mode);
            end
            if (step_en) begin
                rem_q <= rem_nx;
                quo_q <= {quo_q[QBITS-2:0], qbit};
            end
            if (norm_en) begin
                norm_q <= norm_d;
            end
            if (round_en) begin
                res_q <= rounded;
            end
            if (finish) begin
                out_q <= res_q;
            end
        end
    end

    assign done = done_q;
    assign q_hi = out_q[WORD_W-1:HALF_W];
    assign q_lo = out_q[HALF_W-1:0];

endmodule

// File: rtl/spdiv_chk.sv
module spdiv_chk #(
    parameter int unsigned LATENCY = 30
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        sign_a,
    input logic        sign_b,
    input logic [15:0] q_hi,
    input logic [15:0] q_lo
);
    localparam int unsigned TW = $clog2(LATENCY + 3);

    logic [TW-1:0] trk;
    logic          sgn_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk     <= '0;
            sgn_exp <= 1'b0;
        end else if (start && !busy) begin
            trk     <= TW'(1);
            sgn_exp <= sign_a ^ sign_b;
        end else if (done) begin
            trk <= '0;
        end else if (trk != '0 && trk != '1) begin
            trk <= trk + 1'b1;
        end
    end

    // R2: done arrives exactly LATENCY edges after the capturing edge
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> (trk == TW'(LATENCY + 1)));

    // R2: done is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: busy and done never overlap
    p_busy_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R3: result sign is the XOR of the captured operand signs
    p_sign_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (q_hi[15] == sgn_exp));

    // R8: a start during an operation does not end or restart it early
    p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    // R9: result outputs change only together with done
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable({q_hi, q_lo}) |-> done);

endmodule

bind spdiv_seq spdiv_chk #(.LATENCY(LATENCY)) u_spdiv_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .sign_a (a_hi[15]),
    .sign_b (b_hi[15]),
    .q_hi   (q_hi),
    .q_lo   (q_lo)
);

// File: tb/test_spdiv_seq.sv
module test_spdiv_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rnd_mode = 1'b0;
    logic [15:0] a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
    logic        busy, done;
    logic [15:0] q_hi, q_lo;

    always #4 clk = ~clk;

    spdiv_seq i_spdiv_seq (
        .clk(clk), .rst(rst), .start(start), .rnd_mode(rnd_mode),
        .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
        .busy(busy), .done(done), .q_hi(q_hi), .q_lo(q_lo)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct {
        logic [31:0] word;
        int          t0;
        string       req;
    } exp_item_t;

    exp_item_t sb[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // reference from the requirements: long integer division, then window, round
    function automatic logic [31:0] ref_div(input logic [31:0] a, input logic [31:0] b, input logic mode);
        longint unsigned ma, mb, num, q, r, mm;
        int e;
        logic rb, st;
        ma  = longint'({1'b1, a[22:0]});
        mb  = longint'({1'b1, b[22:0]});
        num = ma << 25;
        q   = num / mb;
        r   = num % mb;
        e   = int'(a[30:23]) - int'(b[30:23]) + 127;
        if (q[25]) begin
            mm = (q >> 2) & 64'hFFFFFF; rb = q[1]; st = q[0] | (r != 0);
        end else begin
            mm = (q >> 1) & 64'hFFFFFF; rb = q[0]; st = (r != 0); e = e - 1;
        end
        if (mode == 1'b0 && rb && (st || mm[0])) mm = mm + 1;
        if (mm[24]) begin mm = mm >> 1; e = e + 1; end
        return {a[31] ^ b[31], e[7:0], mm[22:0]};
    endfunction

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic mode,
                         input logic [31:0] expw, input string req);
        exp_item_t it;
        @(negedge clk);
        {a_hi, a_lo} = a;
        {b_hi, b_lo} = b;
        rnd_mode = mode;
        start = 1'b1;
        it.word = expw;
        it.t0   = cyc + 1;
        it.req  = req;
        sb.push_back(it);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R1 busy after start", {31'b0, busy}, 32'h1);
        wait (sb.size() == 0);
    endtask

    // monitor: pop expected items as results appear
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected done", {q_hi, q_lo}, 32'h0);
            end else begin
                exp_item_t it;
                it = sb.pop_front();
                check({q_hi, q_lo} == it.word, it.req, {q_hi, q_lo}, it.word);
                check(cyc - it.t0 == 30, "R2 latency", 32'(cyc - it.t0), 32'd30);
                check(busy == 1'b0, "R2 busy low at done", {31'b0, busy}, 32'h0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(busy == 1'b0 && done == 1'b0, "R9 reset flags", {30'b0, busy, done}, 32'h0);
        check({q_hi, q_lo} == 32'h0, "R9 reset result", {q_hi, q_lo}, 32'h0);

        // directed cases
        issue(32'h3F800000, 32'h3F800000, 1'b0, 32'h3F800000, "R5 1/1");
        issue(32'h3F800000, 32'h40400000, 1'b0, 32'h3EAAAAAB, "R6 1/3 nearest");
        issue(32'h3F800000, 32'h40400000, 1'b1, 32'h3EAAAAAA, "R7 1/3 toward zero");
        issue(32'hBFC00000, 32'h3F000000, 1'b0, 32'hC0400000, "R3 -1.5/0.5");
        issue(32'h40C00000, 32'hC0400000, 1'b1, 32'hC0000000, "R3 6/-3");
        issue(32'h3F800000, 32'h3FC00000, 1'b0, 32'h3F2AAAAB, "R4 1/1.5 leading zero");
        issue(32'h3F800000, 32'h3FC00000, 1'b1, 32'h3F2AAAAA, "R4 R7 1/1.5 truncated");
        issue(32'h3FFFFFFF, 32'h3F800000, 1'b0, 32'h3FFFFFFF, "R5 max mantissa / 1");

        // R8: second start while busy is ignored
        begin
            exp_item_t it;
            @(negedge clk);
            {a_hi, a_lo} = 32'h40A00000;
            {b_hi, b_lo} = 32'h40000000;
            rnd_mode = 1'b0;
            start = 1'b1;
            it.word = 32'h40200000;
            it.t0 = cyc + 1;
            it.req = "R8 result of first operands";
            sb.push_back(it);
            @(negedge clk);
            start = 1'b0;
            repeat (9) @(negedge clk);
            {a_hi, a_lo} = 32'hC1200000;
            {b_hi, b_lo} = 32'h3F400000;
            rnd_mode = 1'b1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait (sb.size() == 0);
            @(negedge clk);
            held = {q_hi, q_lo};
            repeat (40) @(negedge clk);
            check(busy == 1'b0, "R8 no restart", {31'b0, busy}, 32'h0);
            check({q_hi, q_lo} == held, "R9 output held", {q_hi, q_lo}, held);
        end

        // random operands, both modes
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a, b;
            logic m;
            a = {1'($urandom), 8'($urandom_range(154, 100)), 23'($urandom)};
            b = {1'($urandom), 8'($urandom_range(154, 100)), 23'($urandom)};
            m = 1'(i);
            issue(a, b, m, ref_div(a, b, m), m ? "R7 random toward zero" : "R6 random nearest");
        end

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule